// File: doc/BRIEF.md
# Chained Performance Event Counter Bank

This block holds a bank of event counters for hardware performance monitoring. Each counter has its own event strobe and a two-bit mode register that selects idle (cleared), running or held. A running counter adds one for every cycle in which its strobe is high. When it counts past its all-ones value it wraps to zero and raises a sticky overflow flag. Each sticky flag can be routed to a shared interrupt line.

Each counter also has a prescaler that can emit a one-cycle trigger pulse on every 2^n-th counted event. The code n is programmed per counter. The overflow of any counter can freeze a chosen set of running counters, and that set may include the overflowing counter itself. This lets software capture a coherent snapshot of related counts at the moment of interest. A frozen counter keeps its value until software writes the running code again.

Configuration reaches the block as plain register outputs and write strobes from a register file that lies outside this block.

Top module: `perf_chain_counter`

## Requirements
- R1: After reset every count reads 0, every mode reads 0 (idle), every sticky flag is 0, irq_o is 0 and every trigger output is 0.
- R2: In mode 1 (run), the count of a counter whose event strobe is high at a rising edge is one larger on count_o after that edge.
- R3: In mode 0 (idle), the counter and its prescaler are cleared to zero on the next edge, and event strobes have no effect.
- R4: In mode 3 (hold), the count and the prescaler keep their values, and event strobes have no effect.
- R5: A mode write with a data code of 0, 1 or 3 loads that code on the next edge. A write with code 2 is ignored and leaves the mode unchanged.
- R6: A counted event at the all-ones value wraps the count to 0 and sets that counter's sticky flag on the same edge.
- R7: A sticky flag stays set until a 1 is written to its clear bit. If a new overflow happens in the same cycle as the clear, the flag stays set.
- R8: irq_o is high in every cycle in which some counter has both its sticky flag and its interrupt enable set.
- R9: With trigger enabled and interval code n, trg_o of that counter pulses for one cycle after every 2^n-th counted event. Code 0 fires on every event and code 1 fires on every second event.
- R10: An overflow of counter j moves every running counter i whose pause-select bit i*N+j is set into mode 3 on the next edge. This includes i equal to j. An event counted in the overflow cycle is still added.
- R11: A held counter returns to counting only through a mode write of 1. A pause request on a running counter takes priority over a mode write in the same cycle.
- R12: While trigger enable is low, the prescaler is held at zero and no trigger pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N | Per-counter event strobe |
| mode_wr_i | input | N | Per-counter mode write strobe |
| mode_wdata_i | input | 2*N | Mode code to write, two bits per counter |
| irq_en_i | input | N | Per-counter overflow interrupt enable |
| trg_en_i | input | N | Per-counter trigger enable |
| trg_code_i | input | N*CODE_W | Per-counter trigger interval code n (interval 2^n) |
| pause_sel_i | input | N*N | Bit i*N+j: counter i freezes when counter j overflows |
| ovf_clr_i | input | N | Write-one-to-clear strobes for the sticky flags |
| count_o | output | N*CNT_W | Counter values, counter i at bits i*CNT_W upward |
| mode_o | output | 2*N | Current mode per counter |
| ovf_sts_o | output | N | Sticky overflow flags |
| irq_o | output | 1 | Overflow interrupt |
| trg_o | output | N | Per-counter trigger pulses |

## Verification
Counts, modes, sticky flags and trigger pulses are all registered. Each one reflects the inputs sampled at a rising edge one cycle later. irq_o is combinational from the sticky flags, so it rises in the same cycle as the flag that causes it.

The bench drives inputs on the falling edge. It advances its own cycle model on each rising edge and compares every output on the following falling edge. In this way each result is checked in exactly the cycle it is due, and no result is checked a cycle early or late.

Wrap, pause, and the priority cases of set against clear and pause against write are reached on purpose with a narrow counter. Long random sequences then mix all the modes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_HOLD = 2'd3
  } pcc_mode_e;

  // Code 2 carries no meaning, so writes of it are dropped.
  function automatic logic mode_code_legal(input logic [1:0] code);
    return code != 2'd2;
  endfunction

endpackage

// File: rtl/perf_mode_ctl.sv
module perf_mode_ctl
  import pcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_i,
  input  logic [1:0] wdata_i,
  input  logic      pause_i,
  output pcc_mode_e mode_o
);

  pcc_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
    end else if (pause_i && mode_q == MODE_RUN) begin
      // A freeze request outranks a software write in the same cycle.
      mode_q <= MODE_HOLD;
    end else if (wr_i && mode_code_legal(wdata_i)) begin
      mode_q <= pcc_mode_e'(wdata_i);
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/perf_ctr_lane.sv
module perf_ctr_lane #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             evt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             inc_o,
  output logic             ovf_o
);

  logic [CNT_W-1:0] count_q;

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  assign inc_o = run_i & evt_i;
  assign ovf_o = inc_o & at_top(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr_i) begin
      count_q <= '0;
    end else if (inc_o) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/perf_trig_div.sv
module perf_trig_div #(
  parameter int CODE_W = 4,
  parameter int SUB_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              step_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              trg_o
);

  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] limit;
  logic             fire;
  logic             trg_q;

  // Interval 2^n events: the prescaler runs from 0 up to 2^n - 1.
  function automatic logic [SUB_W-1:0] span_mask(input logic [CODE_W-1:0] c);
    return ~({SUB_W{1'b1}} << c);
  endfunction

  assign limit = span_mask(code_i);
  assign fire  = step_i & en_i & (sub_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      trg_q <= 1'b0;
    end else begin
      trg_q <= fire;
      if (clr_i || !en_i) begin
        sub_q <= '0;
      end else if (step_i) begin
        sub_q <= fire ? '0 : sub_q + 1'b1;
      end
    end
  end

  assign trg_o = trg_q;

endmodule

// File: rtl/perf_chain_counter.sv
module perf_chain_counter
  import pcc_pkg::*;
#(
  parameter int N      = 4,
  parameter int CNT_W  = 32,
  parameter int CODE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        evt_i,
  input  logic [N-1:0]        mode_wr_i,
  input  logic [2*N-1:0]      mode_wdata_i,
  input  logic [N-1:0]        irq_en_i,
  input  logic [N-1:0]        trg_en_i,
  input  logic [N*CODE_W-1:0] trg_code_i,
  input  logic [N*N-1:0]      pause_sel_i,
  input  logic [N-1:0]        ovf_clr_i,
  output logic [N*CNT_W-1:0]  count_o,
  output logic [2*N-1:0]      mode_o,
  output logic [N-1:0]        ovf_sts_o,
  output logic                irq_o,
  output logic [N-1:0]        trg_o
);

  localparam int SUB_W = (1 << CODE_W) - 1;

  // Named internal events, visible to the bound checker.
  logic [N-1:0] cnt_inc;
  logic [N-1:0] ovf_evt;
  logic [N-1:0] pause_req;
  logic [N-1:0] run_q;
  logic [N-1:0] idle_q;
  logic [N-1:0] ovf_sts_q;

  for (genvar g = 0; g < N; g++) begin : g_lane
    pcc_mode_e mode_g;

    assign pause_req[g] = |(ovf_evt & pause_sel_i[g*N +: N]);

    perf_mode_ctl u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mode_wr_i[g]),
      .wdata_i (mode_wdata_i[2*g +: 2]),
      .pause_i (pause_req[g]),
      .mode_o  (mode_g)
    );

    assign mode_o[2*g +: 2] = mode_g;
    assign run_q[g]  = (mode_g == MODE_RUN);
    assign idle_q[g] = (mode_g == MODE_IDLE);

    perf_ctr_lane #(.CNT_W(CNT_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run_q[g]),
      .clr_i   (idle_q[g]),
      .evt_i   (evt_i[g]),
      .count_o (count_o[g*CNT_W +: CNT_W]),
      .inc_o   (cnt_inc[g]),
      .ovf_o   (ovf_evt[g])
    );

    perf_trig_div #(.CODE_W(CODE_W), .SUB_W(SUB_W)) u_trg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (idle_q[g]),
      .en_i   (trg_en_i[g]),
      .step_i (cnt_inc[g]),
      .code_i (trg_code_i[g*CODE_W +: CODE_W]),
      .trg_o  (trg_o[g])
    );

    // Sticky flag: a new overflow wins over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_sts_q[g] <= 1'b0;
      end else if (ovf_evt[g]) begin
        ovf_sts_q[g] <= 1'b1;
      end else if (ovf_clr_i[g]) begin
        ovf_sts_q[g] <= 1'b0;
      end
    end
  end

  assign ovf_sts_o = ovf_sts_q;
  assign irq_o     = |(ovf_sts_q & irq_en_i);

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int N     = 4,
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N*CNT_W-1:0] count,
  input logic [2*N-1:0]     mode,
  input logic [N-1:0]       sts,
  input logic [N-1:0]       ovf_evt,
  input logic [N-1:0]       cnt_inc,
  input logic [N-1:0]       pause_req,
  input logic [N-1:0]       trg,
  input logic               irq,
  input logic [N-1:0]       irq_en,
  input logic [N-1:0]       ovf_clr,
  input logic [N-1:0]       mode_wr,
  input logic [2*N-1:0]     mode_wdata
);

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[2*i +: 2] == 2'd0 |=> count[i*CNT_W +: CNT_W] == '0);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[2*i +: 2] == 2'd3 |=> $stable(count[i*CNT_W +: CNT_W]));

    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr[i] && mode_wdata[2*i +: 2] == 2'd2 &&
      !(pause_req[i] && mode[2*i +: 2] == 2'd1) |=> $stable(mode[2*i +: 2]));

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt[i] |=> count[i*CNT_W +: CNT_W] == '0 && sts[i]);

    // R7
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts[i] && !ovf_clr[i] |=> sts[i]);

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts[i] && irq_en[i] |-> irq);

    // R9
    trg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trg[i] |-> $past(cnt_inc[i]));

    // R10
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pause_req[i] && mode[2*i +: 2] == 2'd1 |=> mode[2*i +: 2] == 2'd3);
  end

endmodule

bind perf_chain_counter pcc_checker #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count      (count_o),
  .mode       (mode_o),
  .sts        (ovf_sts_o),
  .ovf_evt    (ovf_evt),
  .cnt_inc    (cnt_inc),
  .pause_req  (pause_req),
  .trg        (trg_o),
  .irq        (irq_o),
  .irq_en     (irq_en_i),
  .ovf_clr    (ovf_clr_i),
  .mode_wr    (mode_wr_i),
  .mode_wdata (mode_wdata_i)
);

// File: tb/sim_perf_chain_counter.sv
module sim_perf_chain_counter;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [N-1:0]    evt, mwr, ien, ten, oclr;
  logic [2*N-1:0]  mwd;
  logic [N*CW-1:0] tcode;
  logic [N*N-1:0]  psel;
  logic [N*W-1:0]  count;
  logic [2*N-1:0]  mode;
  logic [N-1:0]    sts, trg;
  logic            irq;

  perf_chain_counter #(.N(N), .CNT_W(W), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mode_wr_i(mwr), .mode_wdata_i(mwd),
    .irq_en_i(ien), .trg_en_i(ten), .trg_code_i(tcode), .pause_sel_i(psel),
    .ovf_clr_i(oclr), .count_o(count), .mode_o(mode), .ovf_sts_o(sts),
    .irq_o(irq), .trg_o(trg)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model of the requirements.
  int unsigned e_cnt[N];
  int unsigned e_sub[N];
  logic [1:0]  e_mode[N];
  bit          e_sts[N];
  bit          e_trg[N];

  function automatic int unsigned interval_last(input int code);
    return (32'd1 << code) - 1;
  endfunction

  always @(posedge clk) begin
    bit inc[N];
    bit ov[N];
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        e_cnt[i] = 0; e_sub[i] = 0; e_mode[i] = 2'd0; e_sts[i] = 0; e_trg[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        inc[i] = (e_mode[i] == 2'd1) && evt[i];
        ov[i]  = inc[i] && (e_cnt[i] == (1 << W) - 1);
      end
      for (int i = 0; i < N; i++) begin
        bit pr;
        bit fire;
        int code;
        pr = 0;
        for (int j = 0; j < N; j++) if (ov[j] && psel[i*N+j]) pr = 1;
        code = int'(tcode[i*CW +: CW]);
        fire = inc[i] && ten[i] && (e_sub[i] >= interval_last(code));
        e_trg[i] = fire;
        if (e_mode[i] == 2'd0 || !ten[i]) e_sub[i] = 0;
        else if (inc[i]) e_sub[i] = fire ? 0 : e_sub[i] + 1;
        if (e_mode[i] == 2'd0) e_cnt[i] = 0;
        else if (inc[i]) e_cnt[i] = (e_cnt[i] + 1) % (1 << W);
        if (ov[i]) e_sts[i] = 1;
        else if (oclr[i]) e_sts[i] = 0;
        if (pr && e_mode[i] == 2'd1) e_mode[i] = 2'd3;
        else if (mwr[i] && mwd[2*i +: 2] != 2'd2) e_mode[i] = mwd[2*i +: 2];
      end
    end
  end

  task automatic chk(input string req, input int lane, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lane %0d actual=%0h expected=%0h", req, lane, act, exp);
    end
  endtask

  task automatic compare_all();
    bit irq_e;
    irq_e = 0;
    for (int i = 0; i < N; i++) begin
      chk("R2 R3 R4 R6 count", i, 64'(count[i*W +: W]), 64'(e_cnt[i]));
      chk("R5 R10 R11 mode", i, 64'(mode[2*i +: 2]), 64'(e_mode[i]));
      chk("R6 R7 sticky", i, 64'(sts[i]), 64'(e_sts[i]));
      chk("R9 R12 trigger", i, 64'(trg[i]), 64'(e_trg[i]));
      if (e_sts[i] && ien[i]) irq_e = 1;
    end
    chk("R8 irq", 0, 64'(irq), 64'(irq_e));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    mwr = '0;
    oclr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; evt = '0; mwr = '0; mwd = '0; ien = '0; ten = '0; oclr = '0;
    tcode = '0; psel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < N; i++) begin
      chk("R1 count", i, 64'(count[i*W +: W]), 64'd0);
      chk("R1 mode", i, 64'(mode[2*i +: 2]), 64'd0);
      chk("R1 sticky", i, 64'(sts[i]), 64'd0);
      chk("R1 trigger", i, 64'(trg[i]), 64'd0);
    end
    chk("R1 irq", 0, 64'(irq), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // Run all; lane0 trigger every event (R9 code 0), lane1 every 4th, lane2 every 2nd.
    mwr = '1; mwd = 8'b01_01_01_01;
    ten = 4'b0111; tcode = {4'd0, 4'd1, 4'd2, 4'd0};
    ien = 4'b0011;
    step();
    evt = 4'b1111;
    repeat (12) step();
    chk("R2 lane0 twelve events", 0, 64'(count[0 +: W]), 64'd12);

    // R5: code 2 ignored on lane 2; hold lane 3 (R4) then idle it (R3).
    mwr = 4'b1100; mwd = 8'b11_10_00_00;
    step();
    chk("R5 code 2 ignored", 2, 64'(mode[4 +: 2]), 64'd1);
    repeat (3) step();
    chk("R4 held count", 3, 64'(count[3*W +: W]), 64'd13);
    mwr = 4'b1000; mwd = 8'b00_00_00_00;
    step();
    step();
    chk("R3 idle clears", 3, 64'(count[3*W +: W]), 64'd0);

    // R10: lane 0 overflow freezes itself and lane 1.
    psel = '0; psel[0*N+0] = 1'b1; psel[1*N+0] = 1'b1;
    evt = 4'b0001;
    while (count[0 +: W] != 8'hFF) step();
    oclr = 4'b0001;  // R7: set wins over a same-cycle clear
    step();
    chk("R6 wrap", 0, 64'(count[0 +: W]), 64'd0);
    chk("R7 set beats clear", 0, 64'(sts[0]), 64'd1);
    chk("R10 self freeze", 0, 64'(mode[0 +: 2]), 64'd3);
    chk("R10 chained freeze", 1, 64'(mode[2 +: 2]), 64'd3);
    step();
    chk("R8 irq from sticky", 0, 64'(irq), 64'd1);
    oclr = 4'b0001;
    step();
    chk("R7 clear by one", 0, 64'(sts[0]), 64'd0);
    // R11: resume by writing 1.
    mwr = 4'b0001; mwd = 8'b00_00_00_01;
    step();
    chk("R11 resumed", 0, 64'(mode[0 +: 2]), 64'd1);
    step();
    chk("R11 counts again", 0, 64'(count[0 +: W]), 64'd1);
    // R12: trigger disabled on lane 0.
    ten[0] = 1'b0;
    repeat (3) begin
      step();
      chk("R12 no pulse", 0, 64'(trg[0]), 64'd0);
    end

    // Random phase.
    for (int k = 0; k < 4000; k++) begin
      evt = 4'($urandom);
      if ($urandom % 6 == 0) begin
        mwr = 4'($urandom);
        for (int i = 0; i < N; i++) begin
          int pick;
          pick = $urandom % 8;
          mwd[2*i +: 2] = (pick < 4) ? 2'd1 : (pick == 4) ? 2'd0 :
                          (pick == 5) ? 2'd2 : 2'd3;
        end
      end
      if ($urandom % 5 == 0) oclr = 4'($urandom);
      if ($urandom % 50 == 0) ien = 4'($urandom);
      if ($urandom % 40 == 0) ten = 4'($urandom);
      if ($urandom % 40 == 0)
        for (int i = 0; i < N; i++) tcode[i*CW +: CW] = 4'($urandom % 4);
      if ($urandom % 100 == 0) psel = 16'($urandom) & 16'($urandom);
      step();
    end
    finish_run();
  end

endmodule